// File: doc/BRIEF.md
# Edge-Aware Bilinear Pixel Interpolator

This block resamples an RGB image at fractional positions. Each clock it can take one mapped source coordinate (u, v) in signed fixed point, together with the four stored pixels around that position: a (upper-left), b (upper-right), c (lower-left) and d (lower-right). It returns one blended 24-bit pixel per clock at a fixed latency. Fetching the neighbours from line storage is done upstream. This block only weighs and blends them.

From the fractional parts of u and v the block derives four weights. It also tests the integer parts against the image frame, which is 1920 columns by 1080 rows by default. This gives four off-frame flags: one for left, one for right, one for top and one for bottom. Each neighbour that lies past the frame has its weight forced to zero. Corners, edges and the interior therefore all pass through the same pipeline with no stall. The flags come out with the pixel so that a downstream stage can see how the sample was classified.

Top module: `bilerp_edge`

## Requirements
- R1: While reset is held, and until the first result leaves the pipeline, the outputs read as follows: outValid is 0, outPixel is 0 and outFlags is 0.
- R2: A valid input is sampled on a rising edge. Its result appears with outValid high just after the third rising edge that follows. The block accepts a new input every clock. A cycle with inValid low produces a cycle with outValid low, four edges later.
- R3: inU and inV are two's complement values with 8 fractional bits. The integer part is the floor of the value, which is the arithmetic shift right by 8. The fraction du or dv is the low 8 bits. A coordinate with a zero fraction returns neighbour a unchanged.
- R4: The four flags are computed from the integer parts u0 and v0. left is u0 < 0. right is u0+1 > 1919. top is v0 < 0. bottom is v0+1 > 1079. outFlags is {left, right, top, bottom}, with left in bit 3 and bottom in bit 0.
- R5: The outFlags values for these coordinates are 1010 for (-0.2,-0.5), 1000 for (-0.2,50), 1001 for (-0.2,1079.5), 0010 for (50,-0.5), 0001 for (50,1079.5), 0110 for (1919.5,-0.5), 0100 for (1919.5,50) and 0101 for (1919.5,1079.5).
- R6: Neighbour a is dropped when left or top is set. Neighbour b is dropped when right or top is set. Neighbour c is dropped when left or bottom is set. Neighbour d is dropped when right or bottom is set. A dropped neighbour adds nothing to the output.
- R7: The weights carry 16 fractional bits: wa=(256-du)(256-dv), wb=du(256-dv), wc=(256-du)dv and wd=du*dv. With no neighbour dropped they sum to exactly 65536, so a flat colour passes through unchanged.
- R8: Each 8-bit channel (bits 23:16, 15:8, 7:0) is computed on its own as min(255, (sum of pixel*weight + 32768) >> 16).
- R9: While no new result is produced, outPixel and outFlags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Coordinate and neighbours are valid this cycle |
| inU | input | 21 | Column coordinate, signed, 8 fractional bits |
| inV | input | 21 | Row coordinate, signed, 8 fractional bits |
| pixA | input | 24 | Upper-left neighbour, RGB |
| pixB | input | 24 | Upper-right neighbour, RGB |
| pixC | input | 24 | Lower-left neighbour, RGB |
| pixD | input | 24 | Lower-right neighbour, RGB |
| outValid | output | 1 | outPixel and outFlags hold a new result |
| outPixel | output | 24 | Interpolated RGB pixel |
| outFlags | output | 4 | {left, right, top, bottom} off-frame flags of that result |

## Verification
The checks assume three things about the inputs. inValid and the data are known, not X, after reset. Coordinates fit the 13-bit signed integer range. A result that is never flagged at the edge always has its four weights summing to one. The overflow check on the channel sum depends on that, because the sum can never exceed 255 when the weights total at most one. The stimulus draws interior coordinates by a shift-register generator inside [0,1918]x[0,1078]. It adds only the named edge, corner and far-off-frame points, all well inside the 21-bit range. It drives every input at the falling edge.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;

  localparam int NBR_CNT = 4;

  // neighbour slots in every four-wide array
  typedef enum logic [1:0] {
    NBR_A = 2'd0,
    NBR_B = 2'd1,
    NBR_C = 2'd2,
    NBR_D = 2'd3
  } nbr_e;

  // strobes from control to datapath, one per pipeline boundary
  typedef struct packed {
    logic                 ldIn;   // capture coordinate fraction and pixels
    logic                 ldWt;   // compute and register weights
    logic                 ldMul;  // register the channel products
    logic                 ldOut;  // register the rounded result
    logic [NBR_CNT-1:0]   keep;   // neighbour kept at the weight stage
  } stage_strobe_t;

endpackage

// File: rtl/bilerp_ctrl.sv
module bilerp_ctrl
  import bilerp_pkg::*;
#(
  parameter int INT_W = 13,
  parameter int IMG_W = 1920,
  parameter int IMG_H = 1080
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INT_W-1:0]   uInt,
  input  logic [INT_W-1:0]   vInt,
  output stage_strobe_t      strobe,
  output logic               outValid,
  output logic [3:0]         outFlags
);

  localparam int LAST_COL = IMG_W - 1;
  localparam int LAST_ROW = IMG_H - 1;

  int         uI;
  int         vI;
  logic       offLeft;
  logic       offRight;
  logic       offTop;
  logic       offBottom;
  logic [NBR_CNT-1:0] keepNow;

  always_comb begin
    uI        = int'($signed(uInt));
    vI        = int'($signed(vInt));
    offLeft   = (uI < 0);
    offRight  = ((uI + 1) > LAST_COL);
    offTop    = (vI < 0);
    offBottom = ((vI + 1) > LAST_ROW);
    keepNow[NBR_A] = !(offLeft  || offTop);
    keepNow[NBR_B] = !(offRight || offTop);
    keepNow[NBR_C] = !(offLeft  || offBottom);
    keepNow[NBR_D] = !(offRight || offBottom);
  end

  logic               s1Valid, s2Valid, s3Valid;
  logic [3:0]         s1Flags, s2Flags, s3Flags;
  logic [NBR_CNT-1:0] s1Keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      s3Valid  <= 1'b0;
      outValid <= 1'b0;
      s1Flags  <= '0;
      s2Flags  <= '0;
      s3Flags  <= '0;
      outFlags <= '0;
      s1Keep   <= '0;
    end else begin
      s1Valid  <= inValid;
      s2Valid  <= s1Valid;
      s3Valid  <= s2Valid;
      outValid <= s3Valid;
      if (inValid) begin
        s1Flags <= {offLeft, offRight, offTop, offBottom};
        s1Keep  <= keepNow;
      end
      if (s1Valid) s2Flags  <= s1Flags;
      if (s2Valid) s3Flags  <= s2Flags;
      if (s3Valid) outFlags <= s3Flags;
    end
  end

  always_comb begin
    strobe.ldIn  = inValid;
    strobe.ldWt  = s1Valid;
    strobe.ldMul = s2Valid;
    strobe.ldOut = s3Valid;
    strobe.keep  = s1Keep;
  end

  // cycles since reset release, saturating; guards the latency check
  logic [2:0] rstAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstAge <= '0;
    else if (rstAge != 3'd7) rstAge <= rstAge + 3'd1;
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstAge >= 3'd4) |-> (outValid == $past(inValid, 4)));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !s3Valid |=> $stable(outFlags));

endmodule

// File: rtl/bilerp_lane.sv
module bilerp_lane #(
  parameter int CH_W   = 8,
  parameter int FRAC_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ldMul,
  input  logic                          ldOut,
  input  logic [3:0][CH_W-1:0]          chIn,
  input  logic [3:0][2*FRAC_W:0]        wt,
  output logic [CH_W-1:0]               chOut
);

  localparam int WT_W   = 2 * FRAC_W + 1;
  localparam int PROD_W = CH_W + WT_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int SHIFT  = 2 * FRAC_W;
  localparam int RES_W  = SUM_W - SHIFT;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (SHIFT - 1);
  localparam logic [CH_W-1:0]  MAXV = '1;

  logic [3:0][PROD_W-1:0] prod;

  for (genvar i = 0; i < 4; i++) begin : g_mul
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      prod[i] <= '0;
      else if (ldMul) prod[i] <= PROD_W'(chIn[i]) * PROD_W'(wt[i]);
    end
  end

  logic [SUM_W-1:0] sumAll;
  logic [SUM_W-1:0] rounded;
  logic [RES_W-1:0] scaled;
  logic [CH_W-1:0]  clipped;

  always_comb begin
    sumAll = '0;
    for (int i = 0; i < 4; i++) sumAll = sumAll + SUM_W'(prod[i]);
    rounded = sumAll + HALF;
    scaled  = rounded[SUM_W-1:SHIFT];
    clipped = (scaled > RES_W'(MAXV)) ? MAXV : scaled[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      chOut <= '0;
    else if (ldOut) chOut <= clipped;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldOut |-> (scaled <= RES_W'(MAXV)));

endmodule

// File: rtl/bilerp_datapath.sv
module bilerp_datapath
  import bilerp_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int CH_W   = 8,
  parameter int NUM_CH = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  stage_strobe_t                      strobe,
  input  logic [FRAC_W-1:0]                  du,
  input  logic [FRAC_W-1:0]                  dv,
  input  logic [NBR_CNT-1:0][NUM_CH*CH_W-1:0] pixIn,
  output logic [NUM_CH*CH_W-1:0]             pixOut
);

  localparam int PIX_W = NUM_CH * CH_W;
  localparam int WT_W  = 2 * FRAC_W + 1;
  localparam logic [FRAC_W:0]  ONE_F   = (FRAC_W+1)'(1) << FRAC_W;
  localparam logic [WT_W+1:0]  ONE_SUM = (WT_W+2)'(1) << (2 * FRAC_W);

  // stage 1: captured fraction and neighbours
  logic [FRAC_W-1:0]                s1Du, s1Dv;
  logic [NBR_CNT-1:0][PIX_W-1:0]    s1Pix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Du  <= '0;
      s1Dv  <= '0;
      s1Pix <= '0;
    end else if (strobe.ldIn) begin
      s1Du  <= du;
      s1Dv  <= dv;
      s1Pix <= pixIn;
    end
  end

  // weights from the complementary fractions
  logic [FRAC_W:0]               omDu, omDv, exDu, exDv;
  logic [NBR_CNT-1:0][WT_W-1:0]  rawWt;

  always_comb begin
    exDu = {1'b0, s1Du};
    exDv = {1'b0, s1Dv};
    omDu = ONE_F - exDu;
    omDv = ONE_F - exDv;
    rawWt[NBR_A] = WT_W'(omDu) * WT_W'(omDv);
    rawWt[NBR_B] = WT_W'(exDu) * WT_W'(omDv);
    rawWt[NBR_C] = WT_W'(omDu) * WT_W'(exDv);
    rawWt[NBR_D] = WT_W'(exDu) * WT_W'(exDv);
  end

  // stage 2: masked weights, pixels delayed alongside
  logic [NBR_CNT-1:0][WT_W-1:0]  s2Wt;
  logic [NBR_CNT-1:0][PIX_W-1:0] s2Pix;

  for (genvar i = 0; i < NBR_CNT; i++) begin : g_wt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s2Wt[i]  <= '0;
        s2Pix[i] <= '0;
      end else if (strobe.ldWt) begin
        s2Wt[i]  <= strobe.keep[i] ? rawWt[i] : '0;
        s2Pix[i] <= s1Pix[i];
      end
    end

    // R6
    drop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.ldWt && !strobe.keep[i]) |=> (s2Wt[i] == '0));
  end

  // stages 3 and 4: one multiply-sum lane per colour channel
  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    logic [3:0][CH_W-1:0] laneIn;
    for (genvar i = 0; i < NBR_CNT; i++) begin : g_sel
      assign laneIn[i] = s2Pix[i][k*CH_W +: CH_W];
    end

    bilerp_lane #(
      .CH_W   (CH_W),
      .FRAC_W (FRAC_W)
    ) u_lane (
      .clk   (clk),
      .rstN  (rstN),
      .ldMul (strobe.ldMul),
      .ldOut (strobe.ldOut),
      .chIn  (laneIn),
      .wt    (s2Wt),
      .chOut (pixOut[k*CH_W +: CH_W])
    );
  end

  // R7
  weight_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldWt && (&strobe.keep)) |=>
      (({2'b00, s2Wt[0]} + {2'b00, s2Wt[1]} + {2'b00, s2Wt[2]} + {2'b00, s2Wt[3]}) == ONE_SUM));

  // R9
  pixel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldOut |=> $stable(pixOut));

endmodule

// File: rtl/bilerp_edge.sv
module bilerp_edge
  import bilerp_pkg::*;
#(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 8,
  parameter int IMG_W  = 1920,
  parameter int IMG_H  = 1080,
  parameter int CH_W   = 8,
  parameter int NUM_CH = 3,
  localparam int COORD_W = INT_W + FRAC_W,
  localparam int PIX_W   = NUM_CH * CH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [COORD_W-1:0] inU,
  input  logic [COORD_W-1:0] inV,
  input  logic [PIX_W-1:0]   pixA,
  input  logic [PIX_W-1:0]   pixB,
  input  logic [PIX_W-1:0]   pixC,
  input  logic [PIX_W-1:0]   pixD,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPixel,
  output logic [3:0]         outFlags
);

  stage_strobe_t                 strobe;
  logic [NBR_CNT-1:0][PIX_W-1:0] nbrPix;

  assign nbrPix = {pixD, pixC, pixB, pixA};

  bilerp_ctrl #(
    .INT_W (INT_W),
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .uInt     (inU[COORD_W-1:FRAC_W]),
    .vInt     (inV[COORD_W-1:FRAC_W]),
    .strobe   (strobe),
    .outValid (outValid),
    .outFlags (outFlags)
  );

  bilerp_datapath #(
    .FRAC_W (FRAC_W),
    .CH_W   (CH_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .du     (inU[FRAC_W-1:0]),
    .dv     (inV[FRAC_W-1:0]),
    .pixIn  (nbrPix),
    .pixOut (outPixel)
  );

endmodule

// File: tb/bilerp_edge_test.sv
`timescale 1ns/1ps
module bilerp_edge_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [20:0] inU = '0;
  logic [20:0] inV = '0;
  logic [23:0] pixA = '0, pixB = '0, pixC = '0, pixD = '0;
  logic        outValid;
  logic [23:0] outPixel;
  logic [3:0]  outFlags;

  always #2.5 clk = ~clk;

  bilerp_edge uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inU(inU), .inV(inV),
    .pixA(pixA), .pixB(pixB), .pixC(pixC), .pixD(pixD),
    .outValid(outValid), .outPixel(outPixel), .outFlags(outFlags)
  );

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  finished = 0;
  bit  monOn  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [23:0] lastPix = '0;
  logic [3:0]  lastFl  = '0;

  logic [27:0] expQ[$];
  int          cycQ[$];
  string       tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // expected result from the requirements: {left,right,top,bottom,pixel}
  function automatic logic [27:0] refModel(input int u, input int v,
      input logic [23:0] pa, input logic [23:0] pb, input logic [23:0] pc, input logic [23:0] pd);
    int u0, v0, du, dv, s, q;
    bit l, r, t, b;
    int w[4];
    logic [23:0] px[4];
    logic [23:0] res;
    u0 = u >>> 8;  v0 = v >>> 8;
    du = u & 255;  dv = v & 255;
    l = (u0 < 0); r = (u0 + 1 > 1919); t = (v0 < 0); b = (v0 + 1 > 1079);
    w[0] = (256 - du) * (256 - dv);
    w[1] = du * (256 - dv);
    w[2] = (256 - du) * dv;
    w[3] = du * dv;
    if (l || t) w[0] = 0;
    if (r || t) w[1] = 0;
    if (l || b) w[2] = 0;
    if (r || b) w[3] = 0;
    px[0] = pa; px[1] = pb; px[2] = pc; px[3] = pd;
    for (int k = 0; k < 3; k++) begin
      s = 32768;
      for (int i = 0; i < 4; i++) s += int'(px[i][k*8 +: 8]) * w[i];
      q = s >>> 16;
      if (q > 255) q = 255;
      res[k*8 +: 8] = 8'(q);
    end
    return {l, r, t, b, res};
  endfunction

  // scoreboard: results, flags and latency
  always @(negedge clk) begin
    if (monOn && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected outValid", 32'(outValid), 32'd0);
      end else begin
        logic [27:0] e;
        int c;
        string tg;
        e  = expQ.pop_front();
        c  = cycQ.pop_front();
        tg = tagQ.pop_front();
        chk(outPixel == e[23:0], {tg, " pixel"}, 32'(outPixel), 32'(e[23:0]));
        chk(outFlags == e[27:24], {"R4 flags of ", tg}, 32'(outFlags), 32'(e[27:24]));
        chk((cyc - c) == 4, "R2 latency", 32'(cyc - c), 32'd4);
        lastPix = e[23:0];
        lastFl  = e[27:24];
      end
    end
  end

  task automatic drive(input int u, input int v, input logic [23:0] pa, input logic [23:0] pb,
                       input logic [23:0] pc, input logic [23:0] pd, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inU = 21'(u); inV = 21'(v);
    pixA = pa; pixB = pb; pixC = pc; pixD = pd;
    expQ.push_back(refModel(u, v, pa, pb, pc, pd));
    cycQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    inU = 21'h1F_FFFF; inV = 21'h1F_FFFF;
    pixA = 24'hFFFFFF; pixB = 24'hFFFFFF; pixC = 24'hFFFFFF; pixD = 24'hFFFFFF;
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 12; i++) begin
      if (expQ.size() == 0) break;
      @(negedge clk);
    end
    chk(expQ.size() == 0, "R2 all results delivered", 32'(expQ.size()), 32'd0);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic testReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 32'd0);
      chk(outPixel == 24'd0, "R1 outPixel in reset", 32'(outPixel), 32'd0);
      chk(outFlags == 4'd0, "R1 outFlags in reset", 32'(outFlags), 32'd0);
    end
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", 32'(outValid), 32'd0);
    chk(outPixel == 24'd0, "R1 outPixel after reset", 32'(outPixel), 32'd0);
  endtask

  task automatic testFormat();
    drive(100 * 256, 200 * 256, 24'h123456, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, "R3 integer point");
    drive(10 * 256 + 128, 5 * 256, 24'h204060, 24'h406080, 24'h000000, 24'h000000, "R3 half step in u");
    drive(7 * 256, 9 * 256 + 128, 24'h102030, 24'hEEEEEE, 24'h304050, 24'h111111, "R3 half step in v");
    drive(3 * 256 + 1, 4 * 256, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000, "R8 rounding small weight");
    drive(3 * 256 + 128, 4 * 256 + 128, 24'h010101, 24'h000000, 24'h000000, 24'h020202, "R8 rounding half");
    drain();
  endtask

  task automatic testInterior();
    for (int n = 0; n < 40; n++) begin
      logic [31:0] ru, rv, p0, p1;
      lfsr = nextRand(lfsr); ru = lfsr;
      lfsr = nextRand(lfsr); rv = lfsr;
      lfsr = nextRand(lfsr); p0 = lfsr;
      lfsr = nextRand(lfsr); p1 = lfsr;
      if (n < 8)
        drive(int'(ru % 32'd491264), int'(rv % 32'd276224),
              24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, "R7 flat white interior");
      else
        drive(int'(ru % 32'd491264), int'(rv % 32'd276224),
              p0[23:0], p1[23:0], {p0[31:24], p1[31:16]}, p0[27:4], "R8 interior blend");
    end
    drain();
  endtask

  task automatic testEdges();
    logic [23:0] qa, qb, qc, qd;
    qa = 24'h112233; qb = 24'h445566; qc = 24'h778899; qd = 24'hAABBCC;
    drive(-51, -128, qa, qb, qc, qd, "R5 R6 top-left corner");
    drive(-51, 50 * 256, qa, qb, qc, qd, "R5 R6 left edge");
    drive(-51, 1079 * 256 + 128, qa, qb, qc, qd, "R5 R6 bottom-left corner");
    drive(50 * 256, -128, qa, qb, qc, qd, "R5 R6 top edge");
    drive(50 * 256, 1079 * 256 + 128, qa, qb, qc, qd, "R5 R6 bottom edge");
    drive(1919 * 256 + 128, -128, qa, qb, qc, qd, "R5 R6 top-right corner");
    drive(1919 * 256 + 128, 50 * 256, qa, qb, qc, qd, "R5 R6 right edge");
    drive(1919 * 256 + 128, 1079 * 256 + 128, qa, qb, qc, qd, "R5 R6 bottom-right corner");
    drive(-5 * 256 + 64, 20 * 256 + 32, qa, qb, qc, qd, "R4 R6 far left");
    drive(1918 * 256 + 200, 1078 * 256 + 100, qa, qb, qc, qd, "R4 last interior cell");
    drain();
  endtask

  task automatic testBubbles();
    drive(30 * 256 + 17, 40 * 256 + 99, 24'h0A0B0C, 24'h1A1B1C, 24'h2A2B2C, 24'h3A3B3C, "R2 gap pattern a");
    idle();
    idle();
    drive(31 * 256 + 200, 41 * 256 + 3, 24'hC0FFEE, 24'h00FF00, 24'hFF0000, 24'h0000FF, "R2 gap pattern b");
    drive(32 * 256 + 5, 42 * 256 + 250, 24'h808080, 24'h7F7F7F, 24'h404040, 24'hC0C0C0, "R2 gap pattern c");
    idle();
    drive(33 * 256 + 77, 43 * 256 + 77, 24'h55AA55, 24'hAA55AA, 24'h123123, 24'h321321, "R2 gap pattern d");
    drain();
  endtask

  task automatic testHold();
    drive(60 * 256 + 90, 70 * 256 + 10, 24'h135790, 24'h2468AC, 24'hFEDCBA, 24'h010203, "R9 last result");
    drain();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R9 outValid idle", 32'(outValid), 32'd0);
      chk(outPixel == lastPix, "R9 outPixel held", 32'(outPixel), 32'(lastPix));
      chk(outFlags == lastFl, "R9 outFlags held", 32'(outFlags), 32'(lastFl));
    end
  endtask

  initial begin
    testReset();
    testFormat();
    testInterior();
    testEdges();
    testBubbles();
    testHold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog expired got %0d exp %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule